// File: doc/BRIEF.md
# Channel Address Interleave Compactor

The block turns a system address into a compact address local to one memory channel. A request carries the address, a controller index and a channel index. The block scans that controller's table of eight target ranges and takes the first one whose base and limit enclose the address. It subtracts the channel's offset for that range. It then removes the socket interleave and the channel interleave, which gives an address with no holes left by the other sockets and channels. The result comes with the socket-way and channel-way counts of the matched range. Software loads the range table through a single write port before it sends requests.

Removing an interleave takes three steps: shift the address right to the interleave bit position, divide by the way count, and shift the quotient back. The bits below the interleave position are then restored. Socket way counts are always powers of two. Channel way counts may be three, and that case goes through a bit-serial divider. The order of the two steps, and where the restored low bits come from, depend on the channel way count and on the two granularities.

The control path is one state machine:

| State | Role | Transition |
|---|---|---|
| ST_IDLE | Waits for a request. | To ST_SCAN when `req_valid` is seen. |
| ST_SCAN | Tests one range per cycle. | To ST_MISS when the channel index is illegal, or when no range matches after the last one. To ST_LOAD on a hit. |
| ST_LOAD | Subtracts the offset and fixes the step order. | To ST_PREP. |
| ST_PREP | Sets up the current step. A way count that is a power of two is handled here by a shift. | To ST_DIVIDE for three ways, otherwise to ST_MERGE. |
| ST_DIVIDE | Waits for the divide by three. | To ST_MERGE when the divider is done. |
| ST_MERGE | Restores the low bits of the current step. | Back to ST_PREP after the first step, to ST_REPORT after the second. |
| ST_REPORT | Issues the result. | To ST_IDLE. |
| ST_MISS | Issues the result. | To ST_IDLE. |

Top module: `chan_addr_compactor`

## Requirements
- R1: A table write happens on `cfg_we`. The value of `cfg_kind` selects the target: 0 loads a range's lower word, 1 its upper word, 2 its per-channel offset word. Kind 3 is ignored. An offset write with a channel index of 3 or more is ignored.
- R2: A range hits when lower ≤ address ≤ upper. The lower bound is lower-word bits 31..12 placed at bit 26 with zeros below. The upper bound is upper-word bits 31..12 placed at bit 26 with ones in bits 25..0.
- R3: When several ranges enclose the address, the one with the lowest index is used.
- R4: A request that matches no range completes with a one-cycle `done` and `valid`=0. `chan_addr`, `sock_ways` and `chan_ways` are then all zero.
- R5: On a hit, `sock_ways` = 1 << upper-word bits 11..10 and `chan_ways` = upper-word bits 9..8 plus one.
- R6: Lower-word bits 5..4 select the socket interleave position and bits 7..6 select the channel position. The codes 0, 1, 2 and 3 map to bit 6, 8, 12 and 30.
- R7: Before either step, the channel's offset is subtracted from the address, modulo 2^46. The offset is offset-word bits 23..4 placed at bit 26.
- R8: When the channel ways are 3 and the socket position is above the channel position, the channel step runs first and the socket step second. Each step takes its low bits from the value it was given. A step at position s with w ways yields ((v >> s) / w) << s, ORed with the low s bits of its low-bit source.
- R9: In every other case the socket step runs first and the channel step second. Both steps take their low bits from the address as it was before the offset subtraction.
- R10: A request is taken only while `busy` is low. `busy` rises in the next cycle and stays high until the cycle in which `done` pulses for one cycle. `req_valid` is ignored while `busy` is high.
- R11: A request with a channel index of 3 or more completes as a miss.
- R12: After reset, `busy`, `done`, `valid`, `chan_addr` and both way counts are zero. Every table word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_kind | input | 2 | Table word kind: 0 lower, 1 upper, 2 offset, 3 none |
| cfg_ctrl | input | 1 | Controller index of the write |
| cfg_chan | input | 2 | Channel index of an offset write |
| cfg_entry | input | 3 | Range index of the write |
| cfg_data | input | 32 | Word written |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 46 | System address |
| req_ctrl | input | 1 | Controller index of the request |
| req_chan | input | 2 | Channel index of the request |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| valid | output | 1 | The request hit a range (meaningful with `done`) |
| chan_addr | output | 46 | Compacted channel address |
| sock_ways | output | 4 | Socket way count of the hit range |
| chan_ways | output | 3 | Channel way count of the hit range |

## Verification
The bench checks both step orders with three channel ways. Swapping the order, or taking the low bits from the wrong source, corrupts the bits between 26 and 30 whenever an offset and the 30-bit granularity are involved. Overlapping ranges and addresses at a range limit show whether the scan picks the first match and tests the bounds inclusively. Addresses outside every range and illegal channel indexes show whether a miss is reported with cleared outputs. Requests made while busy, and ignored table writes, are checked at the outputs: a design that took them would return a second result or a changed one.

// File: rtl/cai_pkg.sv
package cai_pkg;

    localparam int BOUND_LSB = 26;
    localparam int FIELD_W   = 20;

    typedef enum logic [1:0] {
        CFG_LOWER  = 2'd0,
        CFG_UPPER  = 2'd1,
        CFG_OFFSET = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] lo_field;
        logic [1:0]         chn_gran;
        logic [1:0]         skt_gran;
    } range_lo_t;

    typedef struct packed {
        logic [FIELD_W-1:0] hi_field;
        logic [1:0]         skt_sel;
        logic [1:0]         chn_sel;
    } range_hi_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_LOAD,
        ST_PREP,
        ST_DIVIDE,
        ST_MERGE,
        ST_REPORT,
        ST_MISS
    } cmp_state_e;

    function automatic logic [4:0] gran_to_bit(input logic [1:0] code);
        logic [4:0] pos;
        unique case (code)
            2'd0:    pos = 5'd6;
            2'd1:    pos = 5'd8;
            2'd2:    pos = 5'd12;
            default: pos = 5'd30;
        endcase
        return pos;
    endfunction

endpackage

// File: rtl/cai_table.sv
module cai_table
    import cai_pkg::*;
#(
    parameter int NUM_CTRL = 2,
    parameter int NUM_CHAN = 3,
    parameter int NUM_ENT  = 8,
    parameter int CTRL_W   = 1,
    parameter int CHAN_W   = 2,
    parameter int ENT_W    = 3
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_kind,
    input  logic [CTRL_W-1:0]  wr_ctrl,
    input  logic [CHAN_W-1:0]  wr_chan,
    input  logic [ENT_W-1:0]   wr_entry,
    input  logic [31:0]        wr_data,
    input  logic [CTRL_W-1:0]  rd_ctrl,
    input  logic [CHAN_W-1:0]  rd_chan,
    input  logic [ENT_W-1:0]   rd_entry,
    output range_lo_t          rd_lo,
    output range_hi_t          rd_hi,
    output logic [FIELD_W-1:0] rd_off
);

    range_lo_t          lo_arr  [NUM_CTRL][NUM_ENT];
    range_hi_t          hi_arr  [NUM_CTRL][NUM_ENT];
    logic [FIELD_W-1:0] off_arr [NUM_CTRL][NUM_CHAN][NUM_ENT];

    logic unused_data_bits;
    assign unused_data_bits = ^wr_data[3:0];

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
        for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
            range_lo_t lo_q;
            range_hi_t hi_q;
            logic      hit_slot;
            assign hit_slot = wr_en && (wr_ctrl == CTRL_W'(c)) && (wr_entry == ENT_W'(e));

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lo_q <= '0;
                    hi_q <= '0;
                end else if (hit_slot) begin
                    if (wr_kind == CFG_LOWER) begin
                        lo_q <= '{lo_field: wr_data[31:12], chn_gran: wr_data[7:6],
                                  skt_gran: wr_data[5:4]};
                    end
                    if (wr_kind == CFG_UPPER) begin
                        hi_q <= '{hi_field: wr_data[31:12], skt_sel: wr_data[11:10],
                                  chn_sel: wr_data[9:8]};
                    end
                end
            end
            assign lo_arr[c][e] = lo_q;
            assign hi_arr[c][e] = hi_q;

            for (genvar h = 0; h < NUM_CHAN; h++) begin : g_chan
                logic [FIELD_W-1:0] off_q;
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        off_q <= '0;
                    end else if (hit_slot && wr_kind == CFG_OFFSET
                                 && wr_chan == CHAN_W'(h)) begin
                        off_q <= wr_data[23:4];
                    end
                end
                assign off_arr[c][h][e] = off_q;
            end
        end
    end

    assign rd_lo  = lo_arr[rd_ctrl][rd_entry];
    assign rd_hi  = hi_arr[rd_ctrl][rd_entry];
    assign rd_off = off_arr[rd_ctrl][rd_chan][rd_entry];

endmodule

// File: rtl/cai_range_match.sv
module cai_range_match
    import cai_pkg::*;
#(
    parameter int ADDR_W = 46
)(
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] lo_field,
    input  logic [FIELD_W-1:0] hi_field,
    output logic               hit
);

    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;

    assign lo_addr = ADDR_W'({lo_field, {BOUND_LSB{1'b0}}});
    assign hi_addr = ADDR_W'({hi_field, {BOUND_LSB{1'b1}}});
    assign hit     = (addr >= lo_addr) && (addr <= hi_addr);

endmodule

// File: rtl/cai_div3.sv
module cai_div3 #(
    parameter int W = 46,
    localparam int CNT_W = $clog2(W + 1)
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    output logic         done,
    output logic [W-1:0] quotient
);

    logic [W-1:0]     shreg;
    logic [1:0]       rem;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [2:0]       trial;
    logic             fits;

    assign trial = {rem, shreg[W-1]};
    assign fits  = (trial >= 3'd3);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            rem   <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                shreg <= dividend;
                rem   <= '0;
                cnt   <= CNT_W'(W);
                run   <= 1'b1;
            end else if (run) begin
                shreg <= {shreg[W-2:0], fits};
                rem   <= fits ? 2'(trial - 3'd3) : trial[1:0];
                cnt   <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = shreg;

endmodule

// File: rtl/chan_addr_compactor.sv
module chan_addr_compactor
    import cai_pkg::*;
#(
    parameter int NUM_CTRL = 2,
    parameter int NUM_CHAN = 3,
    parameter int NUM_ENT  = 8,
    parameter int ADDR_W   = 46,
    localparam int CTRL_W  = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int CHAN_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN + 1) : 1,
    localparam int ENT_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [ENT_W-1:0]  cfg_entry,
    input  logic [31:0]       cfg_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CTRL_W-1:0] req_ctrl,
    input  logic [CHAN_W-1:0] req_chan,
    output logic              busy,
    output logic              done,
    output logic              valid,
    output logic [ADDR_W-1:0] chan_addr,
    output logic [3:0]        sock_ways,
    output logic [2:0]        chan_ways
);

    cmp_state_e state, state_n;

    logic [ADDR_W-1:0] addr_orig, addr_run, quot;
    logic [CTRL_W-1:0] ctl_q;
    logic [CHAN_W-1:0] chn_q, chn_rd;
    logic [ENT_W-1:0]  ent_q;
    logic              stage_q, chan_first_q;
    range_lo_t         hit_lo_q;
    range_hi_t         hit_hi_q;

    range_lo_t          tbl_lo;
    range_hi_t          tbl_hi;
    logic [FIELD_W-1:0] tbl_off;
    logic               range_hit;
    logic               chan_ok, last_ent;

    // Table lookup and range compare
    assign chan_ok  = ({1'b0, chn_q} < (CHAN_W + 1)'(NUM_CHAN));
    assign chn_rd   = chan_ok ? chn_q : '0;
    assign last_ent = (ent_q == ENT_W'(NUM_ENT - 1));

    cai_table #(
        .NUM_CTRL (NUM_CTRL),
        .NUM_CHAN (NUM_CHAN),
        .NUM_ENT  (NUM_ENT),
        .CTRL_W   (CTRL_W),
        .CHAN_W   (CHAN_W),
        .ENT_W    (ENT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_kind  (cfg_kind),
        .wr_ctrl  (cfg_ctrl),
        .wr_chan  (cfg_chan),
        .wr_entry (cfg_entry),
        .wr_data  (cfg_data),
        .rd_ctrl  (ctl_q),
        .rd_chan  (chn_rd),
        .rd_entry (ent_q),
        .rd_lo    (tbl_lo),
        .rd_hi    (tbl_hi),
        .rd_off   (tbl_off)
    );

    cai_range_match #(.ADDR_W(ADDR_W)) u_match (
        .addr     (addr_orig),
        .lo_field (tbl_lo.lo_field),
        .hi_field (tbl_hi.hi_field),
        .hit      (range_hit)
    );

    // Step parameters for the interleave removal
    logic [4:0]        skt_bit, chn_bit, cur_shift;
    logic [1:0]        cur_log2;
    logic              step_chan, cur_is3, order_chan_first;
    logic [ADDR_W-1:0] shifted, low_mask, low_src, merged, offset_val;
    logic [ADDR_W-1:0] div_q;
    logic              div_start, div_done;

    assign skt_bit   = gran_to_bit(hit_lo_q.skt_gran);
    assign chn_bit   = gran_to_bit(hit_lo_q.chn_gran);
    assign step_chan = stage_q ^ chan_first_q;
    assign cur_shift = step_chan ? chn_bit : skt_bit;
    assign cur_is3   = step_chan && (hit_hi_q.chn_sel == 2'd2);

    always_comb begin
        if (step_chan) begin
            unique case (hit_hi_q.chn_sel)
                2'd0:    cur_log2 = 2'd0;
                2'd1:    cur_log2 = 2'd1;
                2'd3:    cur_log2 = 2'd2;
                default: cur_log2 = 2'd0;
            endcase
        end else begin
            cur_log2 = hit_hi_q.skt_sel;
        end
    end

    assign order_chan_first = (hit_hi_q.chn_sel == 2'd2) && (skt_bit > chn_bit);
    assign offset_val = ADDR_W'({tbl_off, {BOUND_LSB{1'b0}}});
    assign shifted    = addr_run >> cur_shift;
    assign low_mask   = ~({ADDR_W{1'b1}} << cur_shift);
    assign low_src    = chan_first_q ? addr_run : addr_orig;
    assign merged     = (quot << cur_shift) | (low_src & low_mask);
    assign div_start  = (state == ST_PREP) && cur_is3;

    cai_div3 #(.W(ADDR_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (shifted),
        .done     (div_done),
        .quotient (div_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_n = ST_SCAN;
            ST_SCAN: begin
                if (!chan_ok)       state_n = ST_MISS;
                else if (range_hit) state_n = ST_LOAD;
                else if (last_ent)  state_n = ST_MISS;
            end
            ST_LOAD:   state_n = ST_PREP;
            ST_PREP:   state_n = cur_is3 ? ST_DIVIDE : ST_MERGE;
            ST_DIVIDE: if (div_done) state_n = ST_MERGE;
            ST_MERGE:  state_n = stage_q ? ST_REPORT : ST_PREP;
            ST_REPORT: state_n = ST_IDLE;
            ST_MISS:   state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_orig    <= '0;
            addr_run     <= '0;
            quot         <= '0;
            ctl_q        <= '0;
            chn_q        <= '0;
            ent_q        <= '0;
            stage_q      <= 1'b0;
            chan_first_q <= 1'b0;
            hit_lo_q     <= '0;
            hit_hi_q     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_orig <= req_addr;
                        ctl_q     <= req_ctrl;
                        chn_q     <= req_chan;
                        ent_q     <= '0;
                        stage_q   <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (range_hit) begin
                        hit_lo_q <= tbl_lo;
                        hit_hi_q <= tbl_hi;
                    end else if (!last_ent) begin
                        ent_q <= ent_q + 1'b1;
                    end
                end
                ST_LOAD: begin
                    addr_run     <= addr_orig - offset_val;
                    chan_first_q <= order_chan_first;
                end
                ST_PREP: begin
                    if (!cur_is3) quot <= shifted >> cur_log2;
                end
                ST_DIVIDE: begin
                    if (div_done) quot <= div_q;
                end
                ST_MERGE: begin
                    addr_run <= merged;
                    stage_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            valid     <= 1'b0;
            chan_addr <= '0;
            sock_ways <= '0;
            chan_ways <= '0;
        end else begin
            busy <= (state_n != ST_IDLE);
            done <= 1'b0;
            if (state == ST_REPORT) begin
                done      <= 1'b1;
                valid     <= 1'b1;
                chan_addr <= addr_run;
                sock_ways <= 4'd1 << hit_hi_q.skt_sel;
                chan_ways <= 3'(hit_hi_q.chn_sel) + 3'd1;
            end else if (state == ST_MISS) begin
                done      <= 1'b1;
                valid     <= 1'b0;
                chan_addr <= '0;
                sock_ways <= '0;
                chan_ways <= '0;
            end
        end
    end

endmodule

// File: rtl/cai_checker.sv
module cai_checker #(
    parameter int ADDR_W = 46
)(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              valid,
    input logic [ADDR_W-1:0] chan_addr,
    input logic [3:0]        sock_ways,
    input logic [2:0]        chan_ways
);

    p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_miss_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid) |-> (chan_addr == '0 && sock_ways == 4'd0 && chan_ways == 3'd0));

    p_ways_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && valid) |-> ($countones(sock_ways) == 1 && chan_ways >= 3'd1 && chan_ways <= 3'd4));

endmodule

bind chan_addr_compactor cai_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/chan_addr_compactor_test.sv
`timescale 1ns/1ps
module chan_addr_compactor_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic        cfg_ctrl = '0;
    logic [1:0]  cfg_chan = '0;
    logic [2:0]  cfg_entry = '0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [45:0] req_addr = '0;
    logic        req_ctrl = '0;
    logic [1:0]  req_chan = '0;
    logic        busy, done, valid;
    logic [45:0] chan_addr;
    logic [3:0]  sock_ways;
    logic [2:0]  chan_ways;

    always #2.5 clk = ~clk;

    chan_addr_compactor uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_ctrl(cfg_ctrl), .cfg_chan(cfg_chan), .cfg_entry(cfg_entry),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_addr(req_addr),
        .req_ctrl(req_ctrl), .req_chan(req_chan), .busy(busy), .done(done),
        .valid(valid), .chan_addr(chan_addr), .sock_ways(sock_ways),
        .chan_ways(chan_ways)
    );

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] m_lo  [2][8];
    logic [31:0] m_hi  [2][8];
    logic [31:0] m_off [2][3][8];

    task automatic note(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    function automatic int gmap(input logic [1:0] g);
        case (g)
            2'd0: return 6;
            2'd1: return 8;
            2'd2: return 12;
            default: return 30;
        endcase
    endfunction

    function automatic logic [45:0] strip(input logic [45:0] v, input int s, input int w,
                                          input logic [45:0] low);
        logic [45:0] q;
        q = (v >> s) / 46'(w);
        return (q << s) | (low & ~({46{1'b1}} << s));
    endfunction

    task automatic model(input logic [45:0] a, input int c, input int ch,
                         output bit hit, output logic [45:0] ca,
                         output logic [3:0] sw, output logic [2:0] cw);
        int found = -1;
        hit = 0; ca = '0; sw = '0; cw = '0;
        if (ch < 3) begin
            for (int e = 7; e >= 0; e--) begin
                logic [45:0] lo, hi;
                lo = {m_lo[c][e][31:12], 26'd0};
                hi = {m_hi[c][e][31:12], {26{1'b1}}};
                if (a >= lo && a <= hi) found = e;
            end
        end
        if (found >= 0) begin
            int sb, cb, swi, cwi;
            logic [45:0] r;
            hit = 1;
            swi = 1 << m_hi[c][found][11:10];
            cwi = int'(m_hi[c][found][9:8]) + 1;
            sb  = gmap(m_lo[c][found][5:4]);
            cb  = gmap(m_lo[c][found][7:6]);
            r   = a - {m_off[c][ch][found][23:4], 26'd0};
            if (cwi == 3 && sb > cb) begin
                r = strip(r, cb, cwi, r);
                r = strip(r, sb, swi, r);
            end else begin
                r = strip(r, sb, swi, a);
                r = strip(r, cb, cwi, a);
            end
            ca = r; sw = 4'(swi); cw = 3'(cwi);
        end
    endtask

    task automatic cfg(input int kind, input int c, input int ch, input int e,
                       input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = 2'(kind); cfg_ctrl = c[0]; cfg_chan = 2'(ch);
        cfg_entry = 3'(e); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (kind == 0) m_lo[c][e] = d;
        else if (kind == 1) m_hi[c][e] = d;
        else if (kind == 2 && ch < 3) m_off[c][ch][e] = d;
    endtask

    task automatic issue_exp(input logic [45:0] a, input int c, input int ch,
                             input bit ev, input logic [45:0] eca,
                             input logic [3:0] esw, input logic [2:0] ecw,
                             input string tag);
        int t = 0;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_ctrl = c[0]; req_chan = 2'(ch);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!done) note(0, tag, "timeout", 64'd0, 64'd1);
        else note({valid, chan_addr, sock_ways, chan_ways} == {ev, eca, esw, ecw}, tag,
                  "valid/addr/sw/cw", 64'({valid, chan_addr, sock_ways, chan_ways}),
                  64'({ev, eca, esw, ecw}));
    endtask

    task automatic issue(input logic [45:0] a, input int c, input int ch, input string tag);
        bit h; logic [45:0] ca; logic [3:0] sw; logic [2:0] cw;
        model(a, c, ch, h, ca, sw, cw);
        issue_exp(a, c, ch, h, ca, sw, cw, tag);
    endtask

    initial begin
        #1000000;
        note(0, "watchdog", "expired", 64'd0, 64'd1);
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < 2; c++)
            for (int e = 0; e < 8; e++) begin
                m_lo[c][e] = '0; m_hi[c][e] = '0;
                for (int h = 0; h < 3; h++) m_off[c][h][e] = '0;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        note({busy, done, valid, chan_addr, sock_ways, chan_ways} == '0, "R12", "reset outputs",
             64'({busy, done, valid, chan_addr, sock_ways, chan_ways}), 64'd0);
        // R12: table reset to zero -> entry 0 covers below 2^26, no offset, 1x1 ways
        issue_exp(46'h123, 1, 0, 1'b1, 46'h123, 4'd1, 3'd1, "R12");

        // Directed table on controller 1
        cfg(0, 1, 0, 0, 32'h0000_0040);   // lower 0, socket gran bit 6, channel gran bit 8
        cfg(1, 1, 0, 0, 32'h0000_0200);   // upper 0, 1 socket way, 3 channel ways
        cfg(0, 1, 0, 1, 32'h0000_1020);   // lower 1, socket gran bit 12, channel gran bit 6
        cfg(1, 1, 0, 1, 32'h0000_1600);   // upper 1, 2 socket ways, 3 channel ways
        cfg(2, 1, 1, 1, 32'h0000_0010);   // channel 1 offset one 2^26 unit
        cfg(0, 1, 0, 2, 32'h0000_2000);
        cfg(1, 1, 0, 2, 32'h0000_5300);   // 4 channel ways
        cfg(0, 1, 0, 3, 32'h0000_2000);
        cfg(1, 1, 0, 3, 32'h0000_9100);   // 2 channel ways, overlaps entry 2

        issue_exp(46'h12345, 1, 0, 1'b1, 46'h6145, 4'd1, 3'd3, "R9");
        issue_exp(46'h4012345, 1, 1, 1'b1, 46'h3105, 4'd2, 3'd3, "R8");
        issue(46'h4012345, 1, 1, "R7");
        issue(46'h3FF_FFFF, 1, 0, "R2");
        issue(46'h400_0000, 1, 0, "R2");
        issue_exp(46'hC00_0000, 1, 2, 1'b1, 46'hC00_0000 >> 2, 4'd1, 3'd4, "R3");
        issue((46'd7 << 26) | 46'h55, 1, 0, "R3");
        issue_exp(46'd256 << 26, 1, 0, 1'b0, '0, 4'd0, 3'd0, "R4");
        issue_exp(46'h12345, 1, 3, 1'b0, '0, 4'd0, 3'd0, "R11");

        // R1: ignored writes leave the result unchanged
        cfg(3, 1, 0, 0, 32'hFFFF_FFFF);
        cfg(2, 1, 3, 0, 32'h00FF_FFF0);
        issue_exp(46'h12345, 1, 0, 1'b1, 46'h6145, 4'd1, 3'd3, "R1");

        // R10: request pulses while busy are ignored
        begin
            int t = 0;
            int extra = 0;
            @(negedge clk);
            while (busy) @(negedge clk);
            req_valid = 1'b1; req_addr = 46'h12345; req_ctrl = 1'b1; req_chan = 2'd0;
            @(negedge clk);
            req_addr = 46'h4012345; req_chan = 2'd1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
            while (!done && t < 3000) begin
                @(negedge clk);
                t++;
            end
            note(done && chan_addr == 46'h6145, "R10", "first result kept",
                 64'(chan_addr), 64'h6145);
            repeat (200) begin
                @(negedge clk);
                if (done || busy) extra++;
            end
            note(extra == 0, "R10", "no second request", 64'(extra), 64'd0);
        end

        // Random tables on controller 0
        for (int round = 0; round < 25; round++) begin
            int start = 0;
            for (int e = 0; e < 8; e++) begin
                int len = $urandom_range(1, 6);
                int lo = start;
                int hi = start + len - 1;
                if ($urandom_range(0, 7) == 0) lo = hi + 1;
                start = hi + 1;
                cfg(0, 0, 0, e, (32'(lo) << 12) | (32'($urandom_range(0, 3)) << 6)
                                | (32'($urandom_range(0, 3)) << 4));
                cfg(1, 0, 0, e, (32'(hi) << 12) | (32'($urandom_range(0, 3)) << 10)
                                | (32'($urandom_range(0, 3)) << 8));
                for (int h = 0; h < 3; h++)
                    cfg(2, 0, h, e, 32'($urandom_range(0, (lo > 0) ? lo : 0)) << 4);
            end
            for (int k = 0; k < 12; k++) begin
                logic [45:0] a;
                int ch;
                a  = {20'($urandom_range(0, start + 1)), 26'($urandom)};
                ch = ($urandom_range(0, 7) == 0) ? 3 : $urandom_range(0, 2);
                issue(a, 0, ch, "R6");
            end
        end

        summary();
    end

endmodule